// File: doc/BRIEF.md
# FIFO Loopback Port Controller

This block owns one shared, bidirectional data port and the two single-clock FIFOs behind it. The inbound FIFO takes words from the port, and local logic drains it through a show-ahead read side. The outbound FIFO is filled by local logic, and the port reads it out. In normal operation a direction input decides what a qualified cycle does: it either writes the port data into the inbound FIFO or reads the outbound head onto the port. A cycle is qualified when the active-low port select is low and the active-high port enable is high.

When the active-low loop select is held low, every qualified cycle moves the outbound head straight into the inbound FIFO instead. With direction set to write, the move is silent and the port output stays disabled. With direction set to read, the moved word is also driven on the port. A silent move waits while the inbound FIFO is full, so no word is lost. A shown move goes on draining the outbound FIFO to the port even when the inbound FIFO is full, and those words are not kept inbound. The port output enable is a separate output that stands for the tri-state control.

Top module: `lbp_loop_port`

## Requirements
- R1: After reset both FIFOs are empty (`ob_count` = 0, `ib_count` = 0, `ib_empty` = 1), and `port_oe` = 0.
- R2: With `loop_sel_n` = 1 and a qualified cycle (`port_sel_n` = 0, `port_en` = 1) with `port_dir_wr` = 1, `port_din` is written into the inbound FIFO if it is not full, and `port_oe` stays 0.
- R3: With `loop_sel_n` = 1 and a qualified cycle with `port_dir_wr` = 0, the outbound head is popped if the FIFO is not empty. In the same cycle `port_oe` = 1 and `port_dout` carries that word. Whenever `port_oe` = 0, `port_dout` is all zeros.
- R4: With `loop_sel_n` = 0 and a qualified cycle with `port_dir_wr` = 1, the outbound head moves into the inbound FIFO, and `port_oe` stays 0.
- R5: With `loop_sel_n` = 0 and a qualified cycle with `port_dir_wr` = 0, the outbound head moves into the inbound FIFO and is also shown on `port_dout` with `port_oe` = 1.
- R6: A loop cycle with the outbound FIFO empty writes nothing inbound, and `port_oe` stays 0.
- R7: A silent loop cycle (`port_dir_wr` = 1) with the inbound FIFO full pops nothing from the outbound FIFO.
- R8: A shown loop cycle (`port_dir_wr` = 0) with the inbound FIFO full still pops the outbound head onto the port, and the inbound FIFO is left unchanged.
- R9: When `port_en` = 0 or `port_sel_n` = 1, no port transfer happens and `port_oe` = 0, whatever the direction and loop inputs are.
- R10: `ob_wr_en` writes `ob_wr_data` when `ob_full` = 0. `ib_rd_en` pops the inbound FIFO when it is not empty, and `ib_rd_data` shows the head in the same cycle. `ob_count` and `ib_count` report occupancy after each edge.
- R11: A normal port write to a full inbound FIFO is dropped, and the stored words are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_sel_n | input | 1 | Port select, active low |
| port_en | input | 1 | Port enable, active high |
| port_dir_wr | input | 1 | 1: port writes inbound, 0: port reads outbound |
| loop_sel_n | input | 1 | Loop select, active low |
| port_din | input | W | Port write data |
| port_dout | output | W | Port read data, zero while not enabled |
| port_oe | output | 1 | Port output enable |
| ob_wr_en | input | 1 | Outbound FIFO write strobe |
| ob_wr_data | input | W | Outbound FIFO write data |
| ob_full | output | 1 | Outbound FIFO full |
| ob_count | output | $clog2(OB_DEPTH+1) | Outbound occupancy |
| ib_rd_en | input | 1 | Inbound FIFO read strobe |
| ib_rd_data | output | W | Inbound FIFO head word |
| ib_empty | output | 1 | Inbound FIFO empty |
| ib_count | output | $clog2(IB_DEPTH+1) | Inbound occupancy |

## Verification
The hardest situation to reach is a loop cycle that meets a full inbound FIFO, because both loop directions must be seen there and they behave differently: a silent loop holds, and a shown loop discards inbound. The stimulus uses a small inbound depth. It preloads the outbound FIFO, tops up the inbound FIFO with normal port writes and a couple of silent moves, then issues silent and shown loop cycles against the full FIFO. It then drains the inbound FIFO and runs loop cycles until the outbound FIFO is empty.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  typedef enum logic [2:0] {
    XFER_NONE,
    XFER_PORT_IN,
    XFER_PORT_OUT,
    XFER_LOOP_SILENT,
    XFER_LOOP_SHOWN
  } xfer_mode_e;

endpackage

// File: rtl/lbp_rst_sync.sv
module lbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/lbp_fifo.sv
module lbp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   wdata,
  input  logic                           pop,
  output logic [W-1:0]                   rdata,
  output logic                           full,
  output logic                           empty,
  output logic [$clog2(DEPTH+1)-1:0]     count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr_q] <= wdata;
    end
  end

  assign rdata = mem[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/lbp_port_ctrl.sv
module lbp_port_ctrl
  import lbp_pkg::*;
(
  input  logic port_sel_n,
  input  logic port_en,
  input  logic port_dir_wr,
  input  logic loop_sel_n,
  input  logic ob_empty,
  input  logic ib_full,
  output logic ob_pop,
  output logic ib_push,
  output logic ib_from_loop,
  output logic port_oe
);

  xfer_mode_e mode;
  logic       qualified;

  assign qualified = !port_sel_n && port_en;

  always_comb begin
    if (!qualified) begin
      mode = XFER_NONE;
    end else if (loop_sel_n) begin
      mode = port_dir_wr ? XFER_PORT_IN : XFER_PORT_OUT;
    end else begin
      mode = port_dir_wr ? XFER_LOOP_SILENT : XFER_LOOP_SHOWN;
    end
  end

  always_comb begin
    ob_pop  = 1'b0;
    ib_push = 1'b0;
    port_oe = 1'b0;
    case (mode)
      XFER_PORT_IN: begin
        ib_push = !ib_full;
      end
      XFER_PORT_OUT: begin
        ob_pop  = !ob_empty;
        port_oe = !ob_empty;
      end
      XFER_LOOP_SILENT: begin
        ob_pop  = !ob_empty && !ib_full;
        ib_push = !ob_empty && !ib_full;
      end
      XFER_LOOP_SHOWN: begin
        ob_pop  = !ob_empty;
        port_oe = !ob_empty;
        ib_push = !ob_empty && !ib_full;
      end
      default: begin
        ob_pop  = 1'b0;
        ib_push = 1'b0;
        port_oe = 1'b0;
      end
    endcase
  end

  assign ib_from_loop = !loop_sel_n;

endmodule

// File: rtl/lbp_loop_port.sv
module lbp_loop_port #(
  parameter int W        = 32,
  parameter int IB_DEPTH = 16,
  parameter int OB_DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              port_sel_n,
  input  logic                              port_en,
  input  logic                              port_dir_wr,
  input  logic                              loop_sel_n,
  input  logic [W-1:0]                      port_din,
  output logic [W-1:0]                      port_dout,
  output logic                              port_oe,
  input  logic                              ob_wr_en,
  input  logic [W-1:0]                      ob_wr_data,
  output logic                              ob_full,
  output logic [$clog2(OB_DEPTH+1)-1:0]     ob_count,
  input  logic                              ib_rd_en,
  output logic [W-1:0]                      ib_rd_data,
  output logic                              ib_empty,
  output logic [$clog2(IB_DEPTH+1)-1:0]     ib_count
);

  logic         rst_sync_n;
  logic         ob_pop, ob_empty;
  logic         ib_push, ib_full, ib_from_loop;
  logic [W-1:0] ob_head;
  logic [W-1:0] ib_wdata;

  lbp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lbp_port_ctrl u_ctrl (
    .port_sel_n   (port_sel_n),
    .port_en      (port_en),
    .port_dir_wr  (port_dir_wr),
    .loop_sel_n   (loop_sel_n),
    .ob_empty     (ob_empty),
    .ib_full      (ib_full),
    .ob_pop       (ob_pop),
    .ib_push      (ib_push),
    .ib_from_loop (ib_from_loop),
    .port_oe      (port_oe)
  );

  lbp_fifo #(.W(W), .DEPTH(OB_DEPTH)) u_ob_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (ob_wr_en),
    .wdata (ob_wr_data),
    .pop   (ob_pop),
    .rdata (ob_head),
    .full  (ob_full),
    .empty (ob_empty),
    .count (ob_count)
  );

  assign ib_wdata = ib_from_loop ? ob_head : port_din;

  lbp_fifo #(.W(W), .DEPTH(IB_DEPTH)) u_ib_fifo (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (ib_push),
    .wdata (ib_wdata),
    .pop   (ib_rd_en),
    .rdata (ib_rd_data),
    .full  (ib_full),
    .empty (ib_empty),
    .count (ib_count)
  );

  assign port_dout = port_oe ? ob_head : '0;

endmodule

// File: rtl/lbp_loop_port_chk.sv
module lbp_loop_port_chk #(
  parameter int W        = 32,
  parameter int IB_DEPTH = 16,
  parameter int OB_DEPTH = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              port_sel_n,
  input logic                              port_en,
  input logic                              port_dir_wr,
  input logic                              loop_sel_n,
  input logic [W-1:0]                      port_dout,
  input logic                              port_oe,
  input logic                              ob_wr_en,
  input logic [$clog2(OB_DEPTH+1)-1:0]     ob_count,
  input logic                              ib_rd_en,
  input logic [$clog2(IB_DEPTH+1)-1:0]     ib_count
);

  localparam int OCW = $clog2(OB_DEPTH+1);
  localparam int ICW = $clog2(IB_DEPTH+1);

  logic qual, ob_has, ib_full_c, no_side;

  assign qual      = !port_sel_n && port_en;
  assign ob_has    = (ob_count != '0);
  assign ib_full_c = (ib_count == ICW'(IB_DEPTH));
  assign no_side   = !ob_wr_en && !ib_rd_en;

  // R3
  oe_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_oe |-> (qual && !port_dir_wr && ob_has));

  // R3
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_oe |-> (port_dout == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual && no_side) |=> ($stable(ob_count) && $stable(ib_count)));

  // R7
  silent_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && port_dir_wr && !loop_sel_n && ib_full_c && no_side)
      |=> ($stable(ob_count) && $stable(ib_count)));

  // R5
  shown_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !port_dir_wr && !loop_sel_n && ob_has && !ib_full_c && no_side)
      |=> ((ib_count == $past(ib_count) + ICW'(1)) &&
           (ob_count == $past(ob_count) - OCW'(1))));

  // R8
  shown_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !port_dir_wr && !loop_sel_n && ob_has && ib_full_c && no_side)
      |=> ($stable(ib_count) && (ob_count == $past(ob_count) - OCW'(1))));

  // R6
  loop_dry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && !loop_sel_n && !ob_has && !ib_rd_en) |=> $stable(ib_count));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_count <= ICW'(IB_DEPTH)) && (ob_count <= OCW'(OB_DEPTH)));

endmodule

bind lbp_loop_port lbp_loop_port_chk #(
  .W(W), .IB_DEPTH(IB_DEPTH), .OB_DEPTH(OB_DEPTH)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_sel_n  (port_sel_n),
  .port_en     (port_en),
  .port_dir_wr (port_dir_wr),
  .loop_sel_n  (loop_sel_n),
  .port_dout   (port_dout),
  .port_oe     (port_oe),
  .ob_wr_en    (ob_wr_en),
  .ob_count    (ob_count),
  .ib_rd_en    (ib_rd_en),
  .ib_count    (ib_count)
);

// File: tb/lbp_loop_port_bench.sv
module lbp_loop_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int IBD = 4;
  localparam int OBD = 8;
  localparam int ICW = $clog2(IBD+1);
  localparam int OCW = $clog2(OBD+1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           port_sel_n, port_en, port_dir_wr, loop_sel_n;
  logic [W-1:0]   port_din, port_dout;
  logic           port_oe;
  logic           ob_wr_en;
  logic [W-1:0]   ob_wr_data;
  logic           ob_full;
  logic [OCW-1:0] ob_count;
  logic           ib_rd_en;
  logic [W-1:0]   ib_rd_data;
  logic           ib_empty;
  logic [ICW-1:0] ib_count;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  bit mon_on = 1'b0;

  logic [W-1:0] ob_q[$];
  logic [W-1:0] ib_q[$];
  logic [W-1:0] exp_port[$];
  logic [W-1:0] exp_ib[$];
  bit           exp_oe = 1'b0;
  bit           exp_ib_rd = 1'b0;
  int           exp_obc = 0;
  int           exp_ibc = 0;
  string        cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lbp_loop_port #(.W(W), .IB_DEPTH(IBD), .OB_DEPTH(OBD)) u_lbp_loop_port (
    .clk(clk), .rst_n(rst_n),
    .port_sel_n(port_sel_n), .port_en(port_en), .port_dir_wr(port_dir_wr),
    .loop_sel_n(loop_sel_n), .port_din(port_din), .port_dout(port_dout),
    .port_oe(port_oe), .ob_wr_en(ob_wr_en), .ob_wr_data(ob_wr_data),
    .ob_full(ob_full), .ob_count(ob_count), .ib_rd_en(ib_rd_en),
    .ib_rd_data(ib_rd_data), .ib_empty(ib_empty), .ib_count(ib_count)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected results.
  task automatic drive(input logic sel_n, input logic en, input logic dir_wr,
                       input logic lp_n, input logic [W-1:0] din,
                       input logic obw, input logic [W-1:0] obd,
                       input logic ibr, input string tag);
    bit qual, ob_ne, ob_f, ib_ne, ib_f, pop_ob, push_ib, shown;
    logic [W-1:0] head, word;
    @(negedge clk);
    port_sel_n = sel_n; port_en = en; port_dir_wr = dir_wr; loop_sel_n = lp_n;
    port_din = din; ob_wr_en = obw; ob_wr_data = obd; ib_rd_en = ibr;
    cur_tag = tag;
    qual  = !sel_n && en;
    ob_ne = ob_q.size() != 0;
    ob_f  = ob_q.size() == OBD;
    ib_ne = ib_q.size() != 0;
    ib_f  = ib_q.size() == IBD;
    head  = ob_ne ? ob_q[0] : '0;
    pop_ob = 1'b0; push_ib = 1'b0; shown = 1'b0; word = din;
    if (qual) begin
      if (lp_n) begin
        if (dir_wr) push_ib = !ib_f;
        else begin pop_ob = ob_ne; shown = ob_ne; end
      end else begin
        word = head;
        if (dir_wr) begin pop_ob = ob_ne && !ib_f; push_ib = pop_ob; end
        else begin pop_ob = ob_ne; shown = ob_ne; push_ib = ob_ne && !ib_f; end
      end
    end
    exp_obc = ob_q.size();
    exp_ibc = ib_q.size();
    exp_oe  = shown;
    if (shown) exp_port.push_back(head);
    exp_ib_rd = ibr && ib_ne;
    if (exp_ib_rd) exp_ib.push_back(ib_q[0]);
    if (pop_ob) void'(ob_q.pop_front());
    if (obw && !ob_f) ob_q.push_back(obd);
    if (exp_ib_rd) void'(ib_q.pop_front());
    if (push_ib) ib_q.push_back(word);
  endtask

  task automatic idle(input string tag);
    drive(1'b1, 1'b0, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, tag);
  endtask

  // Monitor: compares the design's outputs with the scoreboard each cycle.
  always begin
    @(negedge clk);
    #2;
    if (mon_on && !done) begin
      check(ob_count == OCW'(exp_obc), cur_tag, "R10 ob_count", 32'(ob_count), 32'(exp_obc));
      check(ib_count == ICW'(exp_ibc), cur_tag, "R10 ib_count", 32'(ib_count), 32'(exp_ibc));
      check(port_oe == exp_oe, cur_tag, "port_oe", 32'(port_oe), 32'(exp_oe));
      if (exp_oe && exp_port.size() != 0) begin
        logic [W-1:0] e;
        e = exp_port.pop_front();
        check(port_dout == e, cur_tag, "port_dout", 32'(port_dout), 32'(e));
      end else begin
        check(port_dout == '0, cur_tag, "R3 quiet port_dout", 32'(port_dout), 32'h0);
      end
      if (exp_ib_rd && exp_ib.size() != 0) begin
        logic [W-1:0] e;
        e = exp_ib.pop_front();
        check(ib_rd_data == e, cur_tag, "R10 ib_rd_data", 32'(ib_rd_data), 32'(e));
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    port_sel_n = 1'b1; port_en = 1'b0; port_dir_wr = 1'b0; loop_sel_n = 1'b1;
    port_din = '0; ob_wr_en = 1'b0; ob_wr_data = '0; ib_rd_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R1: reset state
    check(ob_count == '0, "R1", "ob_count", 32'(ob_count), 32'h0);
    check(ib_count == '0 && ib_empty, "R1", "ib_count", 32'(ib_count), 32'h0);
    check(!port_oe, "R1", "port_oe", 32'(port_oe), 32'h0);
    mon_on = 1'b1;

    // R10: preload outbound FIFO with six words
    for (int i = 0; i < 6; i++)
      drive(1'b1, 1'b0, 1'b0, 1'b1, '0, 1'b1, W'(16'h5100 + i), 1'b0, "R10");
    // R9: unqualified cycles with changing select and direction
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'hdead, 1'b0, '0, 1'b0, "R9");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 16'hdead, 1'b0, '0, 1'b0, "R9");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'hdead, 1'b0, '0, 1'b0, "R9");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 16'hdead, 1'b0, '0, 1'b0, "R9");
    // R3: normal reads
    drive(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, "R3");
    drive(1'b0, 1'b1, 1'b0, 1'b1, '0, 1'b0, '0, 1'b0, "R3");
    // R2: normal writes
    drive(1'b0, 1'b1, 1'b1, 1'b1, 16'ha000, 1'b0, '0, 1'b0, "R2");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 16'ha001, 1'b0, '0, 1'b0, "R2");
    // R4: silent loop moves fill the inbound FIFO
    drive(1'b0, 1'b1, 1'b1, 1'b0, 16'hbeef, 1'b0, '0, 1'b0, "R4");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 16'hbeef, 1'b0, '0, 1'b0, "R4");
    // R7: silent loop against a full inbound FIFO
    drive(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R7");
    drive(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R7");
    // R8: shown loop against a full inbound FIFO
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R8");
    // R10: drain inbound and check stored words
    for (int i = 0; i < 4; i++)
      drive(1'b1, 1'b0, 1'b0, 1'b1, '0, 1'b0, '0, 1'b1, "R10");
    // R5: shown loop move, then one with a concurrent outbound write
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R5");
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b1, 16'h7700, 1'b0, "R5");
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R5");
    // R6: loop cycles on an empty outbound FIFO
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, "R6");
    drive(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R6");
    // R11: normal writes overrun the inbound FIFO
    for (int i = 0; i < 4; i++)
      drive(1'b0, 1'b1, 1'b1, 1'b1, W'(16'hc000 + i), 1'b0, '0, 1'b0, "R11");
    // R10: drain, including a read on empty
    for (int i = 0; i < 5; i++)
      drive(1'b1, 1'b0, 1'b0, 1'b1, '0, 1'b0, '0, 1'b1, "R10");
    idle("R9");
    idle("R9");
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule